// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus, with open-drain clock and data. It gives a bus controller access to a small bank of 8-bit control registers. The system clock samples both lines. The slave recognises its device address and then takes a command byte. The top bit of the command selects one of two access styles. In indexed access, one register is written or read at the offset held in the low seven command bits. In sequential access, the transfer begins at register zero and moves up one register per byte.

Every writable register appears on a parallel output bus, so the surrounding logic can use it as static configuration. One register is read-only and returns an identity byte built from two 4-bit inputs. Four registers are reserved. All storage returns to its default value at reset, so the chip works without ever touching the bus. The slave pulls SDA low through an output enable and never drives the line high.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, `regs_o` equals the `DEFAULTS` parameter (register 0 = FFh, register 1 = 3Ch, register 7 = 81h, register 6 = identity byte, others 00h), and `sda_oe` is 0.
- R2: The slave acknowledges only the 7-bit address 1101010, sent as D4h for writes and D5h for reads, by holding SDA low on the ninth clock. Any other address is not acknowledged, and the bytes that follow, up to the next START, are neither acknowledged nor written.
- R3: A command byte with bit 7 = 1 selects indexed access with offset bits 6:0. A following data byte is acknowledged and stored in that register.
- R4: An indexed read is a write phase (D4h, command), then a repeated START, then D5h. It returns the addressed register, MSB first.
- R5: A command byte with bit 7 = 0 (bits 6:0 = 0) starts sequential access at register 0. Written bytes go to registers 0, 1, 2, … in ascending order. A STOP after any complete byte leaves the bytes already written in place.
- R6: A sequential read after command 00h and a repeated START returns registers 0, 1, 2, … in order. A controller NACK ends the read, and SDA stays released until the next START.
- R7: Register 6 reads as {revision[3:0] in bits 7:4, vendor[3:0] in bits 3:0}, taken from the identity inputs. Writes to it are acknowledged and discarded.
- R8: Reserved registers 2 to 5 read as 00h. Writes to them are acknowledged and discarded.
- R9: `sda_oe` changes only while SCL is low. It is 0 whenever the slave is idle.
- R10: An offset beyond the register bank reads as 00h. A write to such an offset is acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rev_id_i | input | 4 | Revision code for the identity register |
| vendor_id_i | input | 4 | Vendor code for the identity register |
| regs_o | output | NREG*8 | All registers; register k is bits 8k+7:8k |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL low phase lasts well beyond the synchronizer and edge-detect latency of a few system clocks. The stimulus meets both assumptions with a fixed quarter-bit spacing of eight system clocks: the controller moves SDA a quarter bit after SCL falls and samples it in the middle of the high phase. The controller never issues a STOP while the slave is driving an acknowledge or a read bit.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CMD_IDX_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int unsigned       NREG     = 8,
  parameter int unsigned       ID_INDEX = 6,
  parameter logic [NREG-1:0]   WR_MASK  = '0,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CMD_IDX_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [CMD_IDX_W-1:0] rd_idx,
  input  logic [BYTE_W-1:0]    id_byte,
  output logic [NREG*8-1:0]    regs_o,
  output logic [BYTE_W-1:0]    rd_data
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (WR_MASK[i]) begin : g_rw
      logic [BYTE_W-1:0] val_q;
      logic              hit;
      assign hit = wr_en && (wr_idx == CMD_IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= DEFAULTS[i*8 +: 8];
        else if (hit) val_q <= wr_data;
      end
      assign regs_o[i*8 +: 8] = val_q;
    end else if (i == ID_INDEX) begin : g_id
      assign regs_o[i*8 +: 8] = id_byte;
    end else begin : g_fixed
      assign regs_o[i*8 +: 8] = DEFAULTS[i*8 +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == CMD_IDX_W'(k)) rd_data = regs_o[k*8 +: 8];
    end
  end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'b1101010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_lvl,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_lvl,
  input  logic                 sda_rise,
  input  logic                 sda_fall,
  input  logic [BYTE_W-1:0]    rd_data,
  output logic                 wr_en,
  output logic [CMD_IDX_W-1:0] wr_idx,
  output logic [BYTE_W-1:0]    wr_data,
  output logic [CMD_IDX_W-1:0] rd_idx,
  output logic                 sda_oe,
  output smb_state_e           state_o
);
  smb_state_e           state_q, state_d;
  logic [2:0]           cnt_q, cnt_d;
  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic [BYTE_W-1:0]    tx_q, tx_d;
  logic                 got_q, got_d;
  logic                 rnw_q, rnw_d;
  logic                 nack_q, nack_d;
  logic                 oe_q, oe_d;
  logic [CMD_IDX_W-1:0] ptr_q, ptr_d;
  logic                 start_c, stop_c;

  assign start_c = sda_fall & scl_lvl;
  assign stop_c  = sda_rise & scl_lvl;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    got_d   = got_q;
    rnw_d   = rnw_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    if (stop_c) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_c) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      got_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && !got_q) begin
            sh_d = {sh_q[6:0], sda_lvl};
            if (cnt_q == 3'd7) got_d = 1'b1;
            else               cnt_d = cnt_q + 3'd1;
          end else if (scl_fall && got_q) begin
            got_d = 1'b0;
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == ADDR7) begin
                rnw_d   = sh_q[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_CMD) begin
              ptr_d   = sh_q[7] ? sh_q[6:0] : '0;
              oe_d    = 1'b1;
              state_d = ST_CMD_ACK;
            end else begin
              wr_en   = 1'b1;
              ptr_d   = ptr_q + CMD_IDX_W'(1);
              oe_d    = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rnw_q) begin
              tx_d    = rd_data;
              ptr_d   = ptr_q + CMD_IDX_W'(1);
              oe_d    = ~rd_data[7];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_RACK;
            end else begin
              cnt_d = cnt_q + 3'd1;
              tx_d  = {tx_q[6:0], 1'b0};
              oe_d  = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_d = sda_lvl;
          if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IGNORE;
            end else begin
              tx_d    = rd_data;
              ptr_d   = ptr_q + CMD_IDX_W'(1);
              oe_d    = ~rd_data[7];
              state_d = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      got_q   <= 1'b0;
      rnw_q   <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      got_q   <= got_d;
      rnw_q   <= rnw_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
    end
  end

  assign wr_idx  = ptr_q;
  assign wr_data = sh_q;
  assign rd_idx  = ptr_q;
  assign sda_oe  = oe_q;
  assign state_o = state_q;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int unsigned       NREG        = 8,
  parameter int unsigned       ID_INDEX    = 6,
  parameter logic [NREG-1:0]   WR_MASK     = 8'b1000_0011,
  parameter logic [NREG*8-1:0] DEFAULTS    = 64'h8100_0000_0000_3CFF,
  parameter logic [6:0]        ADDR7       = 7'b1101010,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        rev_id_i,
  input  logic [3:0]        vendor_id_i,
  output logic [NREG*8-1:0] regs_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic                 wr_en;
  logic [CMD_IDX_W-1:0] wr_idx, rd_idx;
  logic [BYTE_W-1:0]    wr_data, rd_data;
  smb_state_e           fsm_state;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  smb_proto_fsm #(.ADDR7(ADDR7)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .sda_oe(sda_oe), .state_o(fsm_state)
  );

  smb_reg_bank #(
    .NREG(NREG), .ID_INDEX(ID_INDEX), .WR_MASK(WR_MASK), .DEFAULTS(DEFAULTS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .id_byte({rev_id_i, vendor_id_i}),
    .regs_o(regs_o), .rd_data(rd_data)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
#(
  parameter int unsigned     NREG    = 8,
  parameter logic [NREG-1:0] WR_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input smb_state_e        state
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R9

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe); // R2

  AST_HOST_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe); // R6

  for (genvar i = 0; i < NREG; i++) begin : g_wchk
    if (WR_MASK[i]) begin : g_on
      AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o[i*8 +: 8]) |-> sda_oe); // R3
    end
  end
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG), .WR_MASK(WR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .state(fsm_state)
);

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_oe;
  logic        sda_line;
  logic [63:0] regs_o;
  logic [3:0]  rev = 4'h4;
  logic [3:0]  ven = 4'hB;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [7:0]  expr [8];

  always #4 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  smb_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rev_id_i(rev), .vendor_id_i(ven), .regs_o(regs_o)
  );

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw(1); scl = 1'b1; qw(1); m_low = 1'b1; qw(1); scl = 1'b0; qw(1);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw(1); scl = 1'b1; qw(1); m_low = 1'b0; qw(1);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(1); scl = 1'b1; qw(2); scl = 1'b0; qw(1);
    end
    m_low = 1'b0; qw(1); scl = 1'b1; qw(1); ack = ~sda_line; qw(1); scl = 1'b0; qw(1);
  endtask

  task automatic recv(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b0; qw(1); scl = 1'b1; qw(1); b = {b[6:0], sda_line}; qw(1); scl = 1'b0; qw(1);
    end
    m_low = ~nack; qw(1); scl = 1'b1; qw(2); scl = 1'b0; qw(1);
    m_low = 1'b0;
  endtask

  function automatic logic [63:0] model();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = expr[k];
    return v;
  endfunction

  task automatic byte_write(input string tag, input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    bus_start();
    send(8'hD4, a); chk({tag, " addr ack R2"}, a, 1);
    send(cmd, a);   chk({tag, " cmd ack R3"}, a, 1);
    send(d, a);     chk({tag, " data ack R3"}, a, 1);
    bus_stop();
  endtask

  task automatic byte_read(input string tag, input logic [7:0] cmd, input logic [7:0] exp);
    logic a;
    logic [7:0] d;
    bus_start();
    send(8'hD4, a); send(cmd, a);
    bus_start();
    send(8'hD5, a); chk({tag, " read addr ack R4"}, a, 1);
    recv(1'b1, d);  chk({tag, " read data R4"}, d, exp);
    bus_stop();
  endtask

  task automatic t_reset();
    expr[0] = 8'hFF; expr[1] = 8'h3C; expr[2] = 0; expr[3] = 0;
    expr[4] = 0; expr[5] = 0; expr[6] = {rev, ven}; expr[7] = 8'h81;
    chk("R1 defaults", regs_o, model());
    chk("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_indexed();
    byte_write("R3 reg1", 8'h81, 8'h5A);
    expr[1] = 8'h5A;
    chk("R3 reg1 stored", regs_o, model());
    byte_write("R3 reg7", 8'h87, 8'hC3);
    expr[7] = 8'hC3;
    chk("R3 reg7 stored", regs_o, model());
    byte_read("R4 reg1", 8'h81, 8'h5A);
    byte_read("R4 reg7", 8'h87, 8'hC3);
    chk("R9 idle released", sda_oe, 0);
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    send(8'hA8, a); chk("R2 foreign addr nack", a, 0);
    send(8'h80, a); chk("R2 foreign cmd nack", a, 0);
    send(8'h00, a); chk("R2 foreign data nack", a, 0);
    bus_stop();
    chk("R2 regs untouched", regs_o, model());
  endtask

  task automatic t_block_write();
    logic a;
    logic [7:0] seq [8];
    seq = '{8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA};
    bus_start();
    send(8'hD4, a); send(8'h00, a); chk("R5 block cmd ack", a, 1);
    send(8'h11, a); send(8'h22, a); chk("R5 early data ack", a, 1);
    bus_stop();
    expr[0] = 8'h11; expr[1] = 8'h22;
    chk("R5 early stop keeps bytes", regs_o, model());
    bus_start();
    send(8'hD4, a); send(8'h00, a);
    for (int k = 0; k < 8; k++) begin
      send(seq[k], a);
      chk((k >= 2 && k <= 5) ? "R8 reserved write ack" : (k == 6) ? "R7 id write ack" : "R5 data ack", a, 1);
    end
    bus_stop();
    expr[0] = 8'h33; expr[1] = 8'h44; expr[7] = 8'hAA;
    chk("R5 R7 R8 block result", regs_o, model());
  endtask

  task automatic t_block_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send(8'hD4, a); send(8'h00, a);
    bus_start();
    send(8'hD5, a); chk("R6 block read addr ack", a, 1);
    for (int k = 0; k < 8; k++) begin
      recv(k == 7, d);
      chk((k == 6) ? "R7 id via block read" : (k >= 2 && k <= 5) ? "R8 reserved reads zero" : "R6 block read data", d, expr[k]);
    end
    qw(1);
    chk("R6 released after nack", sda_oe, 0);
    bus_stop();
    bus_start();
    send(8'hD4, a); send(8'h00, a);
    bus_start();
    send(8'hD5, a);
    recv(1'b0, d); chk("R6 short read byte0", d, expr[0]);
    recv(1'b1, d); chk("R6 short read byte1", d, expr[1]);
    bus_stop();
  endtask

  task automatic t_id();
    byte_write("R7 id", 8'h86, 8'h00);
    chk("R7 id write discarded", regs_o, model());
    rev = 4'h9; ven = 4'h2; expr[6] = 8'h92;
    qw(1);
    byte_read("R7 id", 8'h86, 8'h92);
    byte_read("R8 reg3", 8'h83, 8'h00);
  endtask

  task automatic t_range();
    byte_read("R10 far", 8'hFF, 8'h00);
    byte_write("R10 far", 8'hC0, 8'h12);
    chk("R10 far write discarded", regs_o, model());
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_indexed();
    t_foreign();
    t_block_write();
    t_block_read();
    t_id();
    t_range();
    chk("R9 final idle released", sda_oe, 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule